// File: doc/BRIEF.md
# Soft-Step Volume Ramp Controller

This block produces the gain code for a digitally controlled audio volume stage. Software writes a target volume code. The block does not jump to that code. It walks its output one half-decibel code at a time, at a programmable pace, so that a level change causes no audible click. Soft stepping can be turned off, and the output then follows the request on the next clock.

When a dynamic-range compander is enabled, the block adds the compander's signed correction to the requested code. A hold input freezes that correction, so software can change the volume safely: raise hold, wait one blend interval, write the new volume, then release hold. While the compander is on, the blend pace is taken from the compander attack setting and the ordinary time select is ignored. The sum is clamped to the valid code range.

The controller is a three-state machine. **ST_SETTLED** means the output is at rest. **ST_TO_LOUDER** walks toward smaller codes (more gain). **ST_TO_QUIETER** walks toward larger codes (more attenuation). The transitions are:
- **go_louder**: from ST_SETTLED when soft stepping is on and the target code is below the output.
- **go_quieter**: from ST_SETTLED when soft stepping is on and the target code is above the output.
- **arrive**: from a walking state when the last step lands on the target, when the target moves to the output or beyond it, or when soft stepping is turned off.

Top module: `softstep_gain_ramp`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the gain output is code 223 (most attenuated). Code 0 is +32 dB, code 64 is 0 dB, and code 223 is -79.5 dB.
- R2: With soft stepping off, the gain output equals the target code one clock after the target is presented.
- R3: With soft stepping on and the compander off, the output moves by exactly one code per blend interval toward the target, until it equals the target. The blend interval is TICK_BASE × 2^time_sel clocks, with time_sel in 0..7.
- R4: With the compander on, the blend interval is TICK_BASE × 2^attack_sel clocks (attack_sel in 0..3), and time_sel has no effect.
- R5: With the compander on, the target is the volume code plus the compander correction. The correction is two's complement in code units, and a positive value means more attenuation.
- R6: With the compander off, the correction input has no effect on the target.
- R7: The target saturates to code 0 at the loud end and to code 223 at the quiet end. This includes volume codes 224..255, which give 223.
- R8: While hold is high, the correction used is the value captured in the last cycle before hold rose. Changes on the correction input are ignored during that time.
- R9: The busy output is high exactly when the gain output differs from the current target code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vol_code | input | 8 | Requested volume code, 0.5 dB per code |
| soft_en | input | 1 | 1 = ramp gradually, 0 = apply at once |
| time_sel | input | 3 | Blend interval select while the compander is off |
| comp_en | input | 1 | Compander active |
| attack_sel | input | 2 | Compander attack select, sets the blend interval while the compander is on |
| comp_hold | input | 1 | Freeze the compander correction |
| comp_corr | input | 8 | Signed compander correction in code units |
| gain_code | output | 8 | Effective gain code |
| busy | output | 1 | Output not yet at the target |

## Verification
The hardest case to reach is a ramp whose steps fall exactly on the blend grid. The tick counter runs freely, so the first step comes at an unknown phase. For that reason the step-to-step spacing is measured only between consecutive steps, and the arrival is checked against a time bound.

Each ramp starts from a known code. The bench first sets that code with soft stepping off, then turns soft stepping on and writes the new target in the same cycle. The ramps mix directed ones (both directions, both interval sources) with seeded random ones.

The hold case needs the captured correction to differ from the live input. The bench raises hold, changes both the correction and the volume, and expects the sum with the old correction.

// File: rtl/softstep_pkg.sv
package softstep_pkg;
    typedef enum logic [1:0] {
        ST_SETTLED    = 2'd0,
        ST_TO_LOUDER  = 2'd1,
        ST_TO_QUIETER = 2'd2
    } ramp_state_t;
endpackage

// File: rtl/ss_tick_gen.sv
module ss_tick_gen #(
    parameter int TICK_BASE = 8000,
    parameter int SEL_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int MAX_IV = TICK_BASE << ((1 << SEL_W) - 1);
    localparam int CNT_W  = $clog2(MAX_IV + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] interval;

    always_comb begin
        interval = CNT_W'(TICK_BASE) << sel;
        tick     = (cnt_q >= interval - CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + CNT_W'(1);
    end

    // The counter never stays past its wrap point for two cycles in a row (R3)
    assert_tick_wraps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tick) |-> (cnt_q == '0));
endmodule

// File: rtl/ss_target_calc.sv
module ss_target_calc #(
    parameter int CODE_W   = 8,
    parameter int CODE_MAX = 223
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] vol_code,
    input  logic              comp_en,
    input  logic              comp_hold,
    input  logic [CODE_W-1:0] comp_corr,
    output logic [CODE_W-1:0] target
);
    localparam int SUM_W = CODE_W + 2;

    logic [CODE_W-1:0]       corr_q;
    logic signed [SUM_W-1:0] sum;

    always_ff @(posedge clk) begin
        if (!rst_n)          corr_q <= '0;
        else if (!comp_hold) corr_q <= comp_corr;
    end

    always_comb begin
        sum = $signed({2'b00, vol_code});
        if (comp_en)
            sum = sum + $signed({{2{corr_q[CODE_W-1]}}, corr_q});
        if (sum < 0)
            target = '0;
        else if (sum > SUM_W'(CODE_MAX))
            target = CODE_W'(CODE_MAX);
        else
            target = sum[CODE_W-1:0];
    end

    // A held correction does not change (R8)
    assert_hold_freezes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(comp_hold) |-> $stable(corr_q));
    // The target stays inside the legal code range (R7)
    assert_target_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        target <= CODE_W'(CODE_MAX));
endmodule

// File: rtl/softstep_gain_ramp.sv
module softstep_gain_ramp
    import softstep_pkg::*;
#(
    parameter int CODE_W    = 8,
    parameter int CODE_MAX  = 223,
    parameter int TICK_BASE = 8000,
    parameter int SEL_W     = 3,
    parameter int ATT_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] vol_code,
    input  logic              soft_en,
    input  logic [SEL_W-1:0]  time_sel,
    input  logic              comp_en,
    input  logic [ATT_W-1:0]  attack_sel,
    input  logic              comp_hold,
    input  logic [CODE_W-1:0] comp_corr,
    output logic [CODE_W-1:0] gain_code,
    output logic              busy
);
    ramp_state_t       state_q, state_d;
    logic [CODE_W-1:0] target;
    logic [SEL_W-1:0]  eff_sel;
    logic              tick;

    // Compander forces the pace from the attack setting
    always_comb begin
        eff_sel = comp_en ? SEL_W'(attack_sel) : time_sel;
    end

    ss_tick_gen #(.TICK_BASE(TICK_BASE), .SEL_W(SEL_W)) tick_i (
        .clk(clk), .rst_n(rst_n), .sel(eff_sel), .tick(tick)
    );

    ss_target_calc #(.CODE_W(CODE_W), .CODE_MAX(CODE_MAX)) target_i (
        .clk(clk), .rst_n(rst_n), .vol_code(vol_code), .comp_en(comp_en),
        .comp_hold(comp_hold), .comp_corr(comp_corr), .target(target)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SETTLED: begin
                if (soft_en && target < gain_code)      state_d = ST_TO_LOUDER;   // go_louder
                else if (soft_en && target > gain_code) state_d = ST_TO_QUIETER;  // go_quieter
            end
            ST_TO_LOUDER: begin
                if (!soft_en || target >= gain_code)    state_d = ST_SETTLED;     // arrive
                else if (tick && gain_code - CODE_W'(1) == target)
                                                        state_d = ST_SETTLED;     // arrive
            end
            ST_TO_QUIETER: begin
                if (!soft_en || target <= gain_code)    state_d = ST_SETTLED;     // arrive
                else if (tick && gain_code + CODE_W'(1) == target)
                                                        state_d = ST_SETTLED;     // arrive
            end
            default: state_d = ST_SETTLED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SETTLED;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain_code <= CODE_W'(CODE_MAX);
        end else if (!soft_en) begin
            gain_code <= target;
        end else begin
            unique case (state_q)
                ST_TO_LOUDER:
                    if (tick && target < gain_code) gain_code <= gain_code - CODE_W'(1);
                ST_TO_QUIETER:
                    if (tick && target > gain_code) gain_code <= gain_code + CODE_W'(1);
                default: ;
            endcase
        end
    end

    assign busy = (gain_code != target);

    // Soft stepping never moves more than one code per clock (R3)
    assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(soft_en) |-> ((gain_code - $past(gain_code) <= CODE_W'(1)) ||
                            ($past(gain_code) - gain_code <= CODE_W'(1))));
    // Direct mode lands on the previous target (R2)
    assert_direct_apply_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!soft_en) |-> (gain_code == $past(target)));
    // A settled output with a steady target stays settled (R9)
    assert_settled_stays_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!busy) && $stable(target)) |-> !busy);
    // The output code never leaves the legal range (R7)
    assert_gain_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        gain_code <= CODE_W'(CODE_MAX));
endmodule

// File: tb/softstep_gain_ramp_tb.sv
`timescale 1ns/1ps
module softstep_gain_ramp_tb_top;
    localparam int TB = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] vol_code = 8'd223;
    logic       soft_en = 1'b0;
    logic [2:0] time_sel = 3'd0;
    logic       comp_en = 1'b0;
    logic [1:0] attack_sel = 2'd0;
    logic       comp_hold = 1'b0;
    logic [7:0] comp_corr = 8'd0;
    logic [7:0] gain_code;
    logic       busy;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    softstep_gain_ramp #(.TICK_BASE(TB)) dut_i (
        .clk(clk), .rst_n(rst_n), .vol_code(vol_code), .soft_en(soft_en),
        .time_sel(time_sel), .comp_en(comp_en), .attack_sel(attack_sel),
        .comp_hold(comp_hold), .comp_corr(comp_corr),
        .gain_code(gain_code), .busy(busy)
    );

    function automatic int exp_iv(input int sel);
        return TB << sel;
    endfunction

    function automatic int exp_tgt(input int vol, input int corr, input bit comp);
        int s;
        s = vol + (comp ? corr : 0);
        if (s < 0) s = 0;
        if (s > 223) s = 223;
        return s;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic direct(input int vol, input int corr, input bit comp);
        soft_en = 1'b0; comp_en = comp; vol_code = 8'(vol); comp_corr = 8'(corr);
        wait_cyc(3);
    endtask

    task automatic ramp(input int st, input int tg, input int sel, input bit comp, input int att);
        int prev, last, cyc, steps, sp_bad, dir_bad, busy_bad, iv, lim, d;
        string tag;
        tag = comp ? "R4" : "R3";
        time_sel = 3'(sel); attack_sel = 2'(att);
        direct(st, 0, comp);
        iv = comp ? exp_iv(att) : exp_iv(sel);
        d = (tg > st) ? tg - st : st - tg;
        lim = (d + 2) * iv + 6;
        vol_code = 8'(tg); soft_en = 1'b1;
        prev = int'(gain_code); last = -1; cyc = 0; steps = 0;
        sp_bad = 0; dir_bad = 0; busy_bad = 0;
        while (int'(gain_code) != tg && cyc < lim) begin
            @(negedge clk); cyc++;
            if (int'(gain_code) != prev) begin
                if ((tg > prev && int'(gain_code) != prev + 1) ||
                    (tg < prev && int'(gain_code) != prev - 1)) dir_bad++;
                if (last >= 0 && cyc - last != iv) sp_bad++;
                last = cyc; steps++;
            end
            if (busy !== (int'(gain_code) != tg)) busy_bad++;
            prev = int'(gain_code);
        end
        check(int'(gain_code) == tg, {tag, " ramp arrival"}, int'(gain_code), tg);
        check(dir_bad == 0 && steps == d, {tag, " one code per step"}, steps, d);
        check(sp_bad == 0, {tag, " step spacing"}, sp_bad, 0);
        check(busy_bad == 0, "R9 busy during ramp", busy_bad, 0);
        wait_cyc(1);
        check(!busy, "R9 busy low when settled", int'(busy), 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
                $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        int seed;
        seed = 32'd1234;
        void'($urandom(seed));
        wait_cyc(3);
        // R1 reset state
        check(gain_code == 8'd223, "R1 gain in reset", int'(gain_code), 223);
        rst_n = 1'b1;
        @(negedge clk);
        check(gain_code == 8'd223, "R1 gain after reset", int'(gain_code), 223);
        check(!busy, "R9 busy after reset", int'(busy), 0);

        // R2 immediate apply, one clock later
        soft_en = 1'b0; vol_code = 8'd64;
        @(negedge clk);
        check(gain_code == 8'd64, "R2 direct one clock", int'(gain_code), 64);
        vol_code = 8'd10;
        @(negedge clk);
        check(gain_code == 8'd10, "R2 direct second value", int'(gain_code), 10);

        // R7 saturation
        direct(240, 0, 1'b0);
        check(gain_code == 8'd223, "R7 code above range", int'(gain_code), 223);
        direct(200, 100, 1'b1);
        check(gain_code == 8'd223, "R7 quiet clamp", int'(gain_code), 223);
        direct(40, -100, 1'b1);
        check(gain_code == 8'd0, "R7 loud clamp", int'(gain_code), 0);

        // R5 sum, R6 ignored when off
        direct(100, 12, 1'b1);
        check(int'(gain_code) == exp_tgt(100, 12, 1'b1), "R5 sum", int'(gain_code), exp_tgt(100, 12, 1'b1));
        direct(100, -7, 1'b1);
        check(int'(gain_code) == exp_tgt(100, -7, 1'b1), "R5 negative sum", int'(gain_code), exp_tgt(100, -7, 1'b1));
        direct(100, 50, 1'b0);
        check(gain_code == 8'd100, "R6 correction ignored", int'(gain_code), 100);

        // R8 hold
        direct(100, 10, 1'b1);
        comp_hold = 1'b1;
        comp_corr = 8'(-30);
        wait_cyc(3);
        check(gain_code == 8'd110, "R8 held correction", int'(gain_code), 110);
        vol_code = 8'd120;
        wait_cyc(3);
        check(gain_code == 8'd130, "R8 volume change under hold", int'(gain_code), 130);
        comp_hold = 1'b0;
        wait_cyc(3);
        check(gain_code == 8'd90, "R8 release", int'(gain_code), 90);

        // R3 / R4 directed ramps
        ramp(64, 72, 0, 1'b0, 0);
        ramp(72, 60, 2, 1'b0, 0);
        ramp(0, 3, 7, 1'b0, 0);
        ramp(220, 223, 5, 1'b0, 0);
        ramp(100, 95, 7, 1'b1, 1);   // time_sel ignored
        ramp(95, 105, 0, 1'b1, 3);

        // random ramps
        for (int k = 0; k < 10; k++) begin
            int st, tg, sel, att;
            bit cm;
            st  = int'($urandom % 224);
            tg  = st + int'($urandom % 25) - 12;
            if (tg < 0) tg = 0;
            if (tg > 223) tg = 223;
            sel = int'($urandom % 5);
            att = int'($urandom % 4);
            cm  = 1'($urandom % 2);
            ramp(st, tg, sel, cm, att);
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule